// File: doc/BRIEF.md
# Native AUX Request Framer

This block carries one native read or write request over a display auxiliary channel engine. The caller gives a command direction, a 16-bit target address, a byte count and, for writes, the payload. The framer builds a four-byte header, packs header and payload into 32-bit data words (most significant byte first), writes those words into the channel's data slots and then issues a control word that starts the transfer. The control word carries the message size, a timeout selection, a precharge count and a bit-clock divider.

The framer then polls the channel status until its busy flag drops, writes the status flags back to clear them, and decides the outcome. It checks the done flag, the receive-error flag and the timeout flag in a fixed order. On a clean completion it reads the reply words, clips the byte count to what the request asked for, and decodes the reply code from the first reply byte. An acknowledge returns the read data. A defer re-sends the whole message, up to a fixed number of tries. A negative acknowledge ends the request with an error. The wire-level signalling sits behind the channel engine and is not part of this block.

Top module: `aux_native_framer`

## Requirements
- R1: Header byte 0 holds the command in bits 7:4 (0x8 for write, 0x9 for read) with bits 3:0 zero. Byte 1 is address bits 15:8, byte 2 is address bits 7:0 and byte 3 is the byte count minus one.
- R2: A write message is the 4 header bytes followed by the payload bytes, where payload byte i sits at `req_payload[8i+7:8i]`. A read message is the 4 header bytes alone. Message byte 4k+j goes to bits 31-8j:24-8j of data word k. Word k is written with `ch_data_idx`=k, one word per cycle from k=0, for ceil(length/4) words. Unused low bytes of the last word are zero. A data write never coincides with a control write.
- R3: The start control write has bit 31 (busy) set, bits 29 and 28 (error flags) set, bit 30 clear, bits 27:26 = 3 (long timeout), bits 24:20 = message length in bytes, bits 19:16 = 5 and bits 10:0 = 133. All other bits are zero.
- R4: After `ch_status` bit 31 reads 0, exactly one clearing control write follows. It has bit 31 clear, bits 30, 29 and 28 set, and every other field as in the start write.
- R5: Status flags are judged in this order. Done (bit 30) clear gives result 5. Otherwise receive error (bit 28) gives result 4. Otherwise timeout (bit 29) gives result 3.
- R6: The reply byte count is `ch_status` bits 24:20, clipped to the expected size (count+1 for a read, 1 for a write). A clipped count of zero gives result 4.
- R7: The reply code is bits 5:4 of reply byte 0 (bits 29:28 of reply word 0). Code 0 gives result 0. `rd_data` byte i is then reply byte i+1, `rd_count` is the clipped count minus one, and bytes from `rd_count` upward are zero.
- R8: Code 2 (defer) re-sends the whole message. The request is sent at most 7 times in total. A defer on the last try gives result 2.
- R9: Code 1, and the unused code 3, give result 1.
- R10: A byte count of 0 or above 16 gives result 6 one cycle after `req_start`, with no channel write.
- R11: `res_done` is a one-cycle pulse per accepted request. Every failing result leaves `rd_count` 0 and `rd_data` zero. `req_start` is ignored while a request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Start pulse; request fields are sampled with it |
| req_is_read | input | 1 | 1 = native read, 0 = native write |
| req_addr | input | 16 | Target address |
| req_len | input | 5 | Byte count, 1 to 16 |
| req_payload | input | 128 | Write payload, byte i at bits 8i+7:8i |
| ch_data_wr | output | 1 | Data slot write strobe |
| ch_data_idx | output | 3 | Data slot index |
| ch_data_wdata | output | 32 | Data slot word |
| ch_ctl_wr | output | 1 | Control word write strobe |
| ch_ctl_wdata | output | 32 | Control word |
| ch_status | input | 32 | Channel status, same field layout as the control word |
| ch_rd_idx | output | 3 | Reply slot index being read |
| ch_rdata | input | 32 | Reply word at `ch_rd_idx`, same cycle |
| res_done | output | 1 | Request finished (one cycle) |
| res_code | output | 3 | 0 ok, 1 nack, 2 defer limit, 3 timeout, 4 receive fault, 5 not done, 6 bad length |
| rd_count | output | 5 | Read data bytes returned |
| rd_data | output | 128 | Read data, byte i at bits 8i+7:8i |

## Verification
The bench checks the exact packed words for a short write, a read, and a full 16-byte write that ends on a word boundary. A wrong byte order or a missing zero fill shows up as a wrong slot word. It checks the start and clearing control words field by field, so a wrong size, divider or flag is seen. It feeds every status-flag combination that tests the order of judgement, including done clear with a receive error raised, where a wrong order reports the wrong failure. It also sends replies longer than the request and a reply of zero length; a design that does not clip would return stray bytes. Deferral is tested twice. In one run the reply succeeds after two defers. In the other the responder always defers, and a wrong limit shows up as a wrong send count. Bad lengths and a start pulse during a transfer are checked as well; a design that accepted either would show channel writes or an extra result.

// File: rtl/aux_fr_pkg.sv
package aux_fr_pkg;
   // control / status word field positions
   localparam int CTL_BUSY      = 31;
   localparam int CTL_DONE      = 30;
   localparam int CTL_TOERR     = 29;
   localparam int CTL_RXERR     = 28;
   localparam int CTL_TOSEL_LSB = 26;
   localparam int CTL_SIZE_LSB  = 20;
   localparam int CTL_PRE_LSB   = 16;
   localparam int CTL_DIV_LSB   = 0;
   localparam int TOSEL_W       = 2;
   localparam int SIZE_W        = 5;
   localparam int PRE_W         = 4;
   localparam int DIV_W         = 11;

   typedef enum logic [2:0] {
      RES_OK          = 3'd0,
      RES_NACK        = 3'd1,
      RES_DEFER_LIMIT = 3'd2,
      RES_TIMEOUT     = 3'd3,
      RES_RXFAULT     = 3'd4,
      RES_NOTDONE     = 3'd5,
      RES_BADLEN      = 3'd6
   } aux_res_e;

   typedef enum logic [1:0] {
      RPL_ACK   = 2'd0,
      RPL_NACK  = 2'd1,
      RPL_DEFER = 2'd2,
      RPL_RSVD  = 2'd3
   } aux_rpl_e;

   typedef struct packed {
      logic              done;
      logic              to_err;
      logic              rx_err;
      logic [SIZE_W-1:0] size;
   } aux_stat_t;
endpackage

// File: rtl/aux_fr_packer.sv
module aux_fr_packer #(
   parameter int         MAX_PAYLOAD = 16,
   parameter int         LEN_W       = 5,
   parameter int         NWORDS      = 5,
   parameter logic [3:0] WR_CMD      = 4'h8,
   parameter logic [3:0] RD_CMD      = 4'h9,
   localparam int        MSG_MAX     = MAX_PAYLOAD + 4
) (
   input  logic                     is_read,
   input  logic [15:0]              addr,
   input  logic [LEN_W-1:0]         len,
   input  logic [MAX_PAYLOAD*8-1:0] payload,
   output logic [LEN_W:0]           msg_len,
   output logic [NWORDS*32-1:0]     words
);
   logic [7:0] mb [MSG_MAX];

   always_comb begin
      mb[0] = {(is_read ? RD_CMD : WR_CMD), 4'h0};
      mb[1] = addr[15:8];
      mb[2] = addr[7:0];
      mb[3] = 8'(len) - 8'd1;
      for (int i = 0; i < MAX_PAYLOAD; i++) begin
         mb[4+i] = (!is_read && (i < int'(len))) ? payload[8*i +: 8] : 8'h00;
      end
      msg_len = is_read ? (LEN_W+1)'(4) : ((LEN_W+1)'(len) + (LEN_W+1)'(4));
   end

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      for (genvar j = 0; j < 4; j++) begin : g_lane
         localparam int K = 4*w + j;
         if (K < MSG_MAX) begin : g_used
            assign words[32*w + 24 - 8*j +: 8] = mb[K];
         end else begin : g_pad
            assign words[32*w + 24 - 8*j +: 8] = 8'h00;
         end
      end
   end
endmodule

// File: rtl/aux_fr_ctlgen.sv
module aux_fr_ctlgen
   import aux_fr_pkg::*;
#(
   parameter int LEN_W     = 5,
   parameter int TOSEL     = 3,
   parameter int PRECHARGE = 5,
   parameter int CLK_DIV   = 133
) (
   input  logic           clear,
   input  logic [LEN_W:0] msg_len,
   output logic [31:0]    word
);
   always_comb begin
      word = '0;
      word[CTL_BUSY]  = !clear;
      word[CTL_DONE]  = clear;
      word[CTL_TOERR] = 1'b1;
      word[CTL_RXERR] = 1'b1;
      word[CTL_TOSEL_LSB +: TOSEL_W] = TOSEL_W'(TOSEL);
      word[CTL_SIZE_LSB  +: SIZE_W]  = SIZE_W'(msg_len);
      word[CTL_PRE_LSB   +: PRE_W]   = PRE_W'(PRECHARGE);
      word[CTL_DIV_LSB   +: DIV_W]   = DIV_W'(CLK_DIV);
   end
endmodule

// File: rtl/aux_fr_unpacker.sv
module aux_fr_unpacker #(
   parameter int MAX_PAYLOAD = 16,
   parameter int NRWORDS     = 5,
   parameter int RIDX_W      = 3,
   parameter int CNT_W       = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     wr_en,
   input  logic [RIDX_W-1:0]        wr_idx,
   input  logic [31:0]              wr_word,
   input  logic [CNT_W-1:0]         rcount,
   output logic [1:0]               code,
   output logic [MAX_PAYLOAD*8-1:0] data
);
   logic [31:0] rw [NRWORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NRWORDS; i++) rw[i] <= '0;
      end else if (clr) begin
         for (int i = 0; i < NRWORDS; i++) rw[i] <= '0;
      end else if (wr_en && (int'(wr_idx) < NRWORDS)) begin
         rw[wr_idx] <= wr_word;
      end
   end

   assign code = rw[0][29:28];

   for (genvar i = 0; i < MAX_PAYLOAD; i++) begin : g_byte
      localparam int K = i + 1;
      assign data[8*i +: 8] = (CNT_W'(K) < rcount) ? rw[K/4][31 - 8*(K%4) -: 8] : 8'h00;
   end
endmodule

// File: rtl/aux_native_framer.sv
module aux_native_framer
   import aux_fr_pkg::*;
#(
   parameter int         MAX_PAYLOAD = 16,
   parameter int         MAX_TRIES   = 7,
   parameter int         TOSEL       = 3,
   parameter int         PRECHARGE   = 5,
   parameter int         CLK_DIV     = 133,
   parameter logic [3:0] WR_CMD      = 4'h8,
   parameter logic [3:0] RD_CMD      = 4'h9,
   localparam int        LEN_W       = $clog2(MAX_PAYLOAD + 1),
   localparam int        NWORDS      = (MAX_PAYLOAD + 4 + 3) / 4,
   localparam int        NRWORDS     = (MAX_PAYLOAD + 1 + 3) / 4,
   localparam int        WIDX_W      = (NWORDS  > 1) ? $clog2(NWORDS)  : 1,
   localparam int        RIDX_W      = (NRWORDS > 1) ? $clog2(NRWORDS) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_start,
   input  logic                     req_is_read,
   input  logic [15:0]              req_addr,
   input  logic [LEN_W-1:0]         req_len,
   input  logic [MAX_PAYLOAD*8-1:0] req_payload,
   output logic                     ch_data_wr,
   output logic [WIDX_W-1:0]        ch_data_idx,
   output logic [31:0]              ch_data_wdata,
   output logic                     ch_ctl_wr,
   output logic [31:0]              ch_ctl_wdata,
   input  logic [31:0]              ch_status,
   output logic [RIDX_W-1:0]        ch_rd_idx,
   input  logic [31:0]              ch_rdata,
   output logic                     res_done,
   output logic [2:0]               res_code,
   output logic [LEN_W-1:0]         rd_count,
   output logic [MAX_PAYLOAD*8-1:0] rd_data
);
   localparam int CNT_W   = LEN_W + 1;
   localparam int TRIES_W = $clog2(MAX_TRIES + 1);

   if (MAX_PAYLOAD < 1 || MAX_PAYLOAD + 4 > 31) begin : g_bad_payload
      $error("MAX_PAYLOAD must fit the message size field");
   end
   if (MAX_TRIES < 1) begin : g_bad_tries
      $error("MAX_TRIES must be at least 1");
   end
   if (PRECHARGE > 15 || CLK_DIV > 2047 || TOSEL > 3) begin : g_bad_ctl
      $error("control field value too wide");
   end

   typedef enum logic [2:0] {
      ST_IDLE, ST_LOAD, ST_KICK, ST_WAIT, ST_CLEAR, ST_READ, ST_CLASS
   } st_e;

   st_e                      state_q;
   logic                     is_rd_q;
   logic [15:0]              addr_q;
   logic [LEN_W-1:0]         len_q;
   logic [MAX_PAYLOAD*8-1:0] pay_q;
   logic [WIDX_W-1:0]        widx_q;
   logic [RIDX_W-1:0]        ridx_q;
   logic [TRIES_W-1:0]       tries_q;
   aux_stat_t                stat_q;
   logic [CNT_W-1:0]         rcnt_q;
   logic                     done_q;
   aux_res_e                 res_q;
   logic [LEN_W-1:0]         rd_cnt_q;
   logic [MAX_PAYLOAD*8-1:0] rd_data_q;

   logic [LEN_W:0]           msg_len;
   logic [NWORDS*32-1:0]     words;
   logic [WIDX_W-1:0]        wlast;
   logic [CNT_W-1:0]         rexp;
   logic [CNT_W-1:0]         rclip;
   logic [RIDX_W-1:0]        rlast;
   logic [1:0]               rpl_code;
   logic [MAX_PAYLOAD*8-1:0] unpacked;
   logic                     len_bad;
   logic                     fsm_idle;

   aux_fr_packer #(
      .MAX_PAYLOAD(MAX_PAYLOAD), .LEN_W(LEN_W), .NWORDS(NWORDS),
      .WR_CMD(WR_CMD), .RD_CMD(RD_CMD)
   ) u_pack (
      .is_read(is_rd_q), .addr(addr_q), .len(len_q), .payload(pay_q),
      .msg_len(msg_len), .words(words)
   );

   aux_fr_ctlgen #(
      .LEN_W(LEN_W), .TOSEL(TOSEL), .PRECHARGE(PRECHARGE), .CLK_DIV(CLK_DIV)
   ) u_ctl (
      .clear(state_q == ST_CLEAR), .msg_len(msg_len), .word(ch_ctl_wdata)
   );

   aux_fr_unpacker #(
      .MAX_PAYLOAD(MAX_PAYLOAD), .NRWORDS(NRWORDS), .RIDX_W(RIDX_W), .CNT_W(CNT_W)
   ) u_unpack (
      .clk(clk), .rst_n(rst_n),
      .clr(state_q == ST_IDLE && req_start),
      .wr_en(state_q == ST_READ), .wr_idx(ridx_q), .wr_word(ch_rdata),
      .rcount(rcnt_q), .code(rpl_code), .data(unpacked)
   );

   assign fsm_idle = (state_q == ST_IDLE);
   assign len_bad  = (req_len == '0) || (int'(req_len) > MAX_PAYLOAD);
   assign wlast    = WIDX_W'((msg_len + (LEN_W+1)'(3)) >> 2) - WIDX_W'(1);
   assign rexp     = is_rd_q ? (CNT_W'(len_q) + CNT_W'(1)) : CNT_W'(1);
   assign rclip    = (CNT_W'(stat_q.size) > rexp) ? rexp : CNT_W'(stat_q.size);
   assign rlast    = RIDX_W'((rcnt_q - CNT_W'(1)) >> 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         is_rd_q   <= 1'b0;
         addr_q    <= '0;
         len_q     <= '0;
         pay_q     <= '0;
         widx_q    <= '0;
         ridx_q    <= '0;
         tries_q   <= '0;
         stat_q    <= '0;
         rcnt_q    <= '0;
         done_q    <= 1'b0;
         res_q     <= RES_OK;
         rd_cnt_q  <= '0;
         rd_data_q <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_start) begin
                  rd_cnt_q  <= '0;
                  rd_data_q <= '0;
                  if (len_bad) begin
                     res_q  <= RES_BADLEN;
                     done_q <= 1'b1;
                  end else begin
                     is_rd_q <= req_is_read;
                     addr_q  <= req_addr;
                     len_q   <= req_len;
                     pay_q   <= req_payload;
                     widx_q  <= '0;
                     tries_q <= '0;
                     state_q <= ST_LOAD;
                  end
               end
            end
            ST_LOAD: begin
               if (widx_q == wlast) state_q <= ST_KICK;
               else                 widx_q  <= widx_q + WIDX_W'(1);
            end
            ST_KICK: begin
               tries_q <= tries_q + TRIES_W'(1);
               state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (!ch_status[CTL_BUSY]) begin
                  stat_q.done   <= ch_status[CTL_DONE];
                  stat_q.to_err <= ch_status[CTL_TOERR];
                  stat_q.rx_err <= ch_status[CTL_RXERR];
                  stat_q.size   <= ch_status[CTL_SIZE_LSB +: SIZE_W];
                  state_q       <= ST_CLEAR;
               end
            end
            ST_CLEAR: begin
               if (!stat_q.done) begin
                  res_q <= RES_NOTDONE; done_q <= 1'b1; state_q <= ST_IDLE;
               end else if (stat_q.rx_err) begin
                  res_q <= RES_RXFAULT; done_q <= 1'b1; state_q <= ST_IDLE;
               end else if (stat_q.to_err) begin
                  res_q <= RES_TIMEOUT; done_q <= 1'b1; state_q <= ST_IDLE;
               end else if (rclip == '0) begin
                  res_q <= RES_RXFAULT; done_q <= 1'b1; state_q <= ST_IDLE;
               end else begin
                  rcnt_q  <= rclip;
                  ridx_q  <= '0;
                  state_q <= ST_READ;
               end
            end
            ST_READ: begin
               if (ridx_q == rlast) state_q <= ST_CLASS;
               else                 ridx_q  <= ridx_q + RIDX_W'(1);
            end
            ST_CLASS: begin
               case (aux_rpl_e'(rpl_code))
                  RPL_ACK: begin
                     res_q     <= RES_OK;
                     rd_cnt_q  <= LEN_W'(rcnt_q - CNT_W'(1));
                     rd_data_q <= unpacked;
                     done_q    <= 1'b1;
                     state_q   <= ST_IDLE;
                  end
                  RPL_DEFER: begin
                     if (int'(tries_q) >= MAX_TRIES) begin
                        res_q <= RES_DEFER_LIMIT; done_q <= 1'b1; state_q <= ST_IDLE;
                     end else begin
                        widx_q  <= '0;
                        state_q <= ST_LOAD;
                     end
                  end
                  default: begin
                     res_q <= RES_NACK; done_q <= 1'b1; state_q <= ST_IDLE;
                  end
               endcase
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ch_data_wr    = (state_q == ST_LOAD);
   assign ch_data_idx   = widx_q;
   assign ch_data_wdata = words[32*int'(widx_q) +: 32];
   assign ch_ctl_wr     = (state_q == ST_KICK) || (state_q == ST_CLEAR);
   assign ch_rd_idx     = ridx_q;
   assign res_done      = done_q;
   assign res_code      = res_q;
   assign rd_count      = rd_cnt_q;
   assign rd_data       = rd_data_q;
endmodule

// File: rtl/aux_fr_chk.sv
module aux_fr_chk #(
   parameter int MAX_PAYLOAD = 16,
   parameter int PRECHARGE   = 5,
   parameter int CLK_DIV     = 133,
   parameter int LEN_W       = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             idle,
   input logic             req_start,
   input logic [LEN_W-1:0] req_len,
   input logic             ch_data_wr,
   input logic             ch_ctl_wr,
   input logic [31:0]      ch_ctl_wdata,
   input logic [31:0]      ch_status,
   input logic             res_done,
   input logic [2:0]       res_code,
   input logic [LEN_W-1:0] rd_count
);
   p_one_writer_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(ch_data_wr && ch_ctl_wr));

   p_start_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_ctl_wr && ch_ctl_wdata[31]) |->
         (ch_ctl_wdata[19:16] == 4'(PRECHARGE)) && (ch_ctl_wdata[10:0] == 11'(CLK_DIV)) &&
         ch_ctl_wdata[29] && ch_ctl_wdata[28] && !ch_ctl_wdata[30] &&
         (ch_ctl_wdata[24:20] >= 5'd4));

   p_clear_after_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_ctl_wr && !ch_ctl_wdata[31]) |->
         ch_ctl_wdata[30] && ch_ctl_wdata[29] && ch_ctl_wdata[28] && $past(!ch_status[31]));

   p_badlen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && req_start && ((req_len == '0) || (int'(req_len) > MAX_PAYLOAD))) |=>
         (res_done && res_code == 3'd6 && !ch_data_wr && !ch_ctl_wr));

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |=> !res_done);

   p_fail_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (res_done && res_code != 3'd0) |-> (rd_count == '0));

   p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |-> (int'(rd_count) <= MAX_PAYLOAD));
endmodule

bind aux_native_framer aux_fr_chk #(
   .MAX_PAYLOAD(MAX_PAYLOAD), .PRECHARGE(PRECHARGE), .CLK_DIV(CLK_DIV), .LEN_W(LEN_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .idle(fsm_idle), .req_start(req_start), .req_len(req_len),
   .ch_data_wr(ch_data_wr), .ch_ctl_wr(ch_ctl_wr), .ch_ctl_wdata(ch_ctl_wdata),
   .ch_status(ch_status), .res_done(res_done), .res_code(res_code), .rd_count(rd_count)
);

// File: tb/aux_native_framer_tb.sv
module aux_native_framer_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_start = 1'b0;
   logic         req_is_read = 1'b0;
   logic [15:0]  req_addr = '0;
   logic [4:0]   req_len = '0;
   logic [127:0] req_payload = '0;
   logic         ch_data_wr;
   logic [2:0]   ch_data_idx;
   logic [31:0]  ch_data_wdata;
   logic         ch_ctl_wr;
   logic [31:0]  ch_ctl_wdata;
   logic [31:0]  ch_status;
   logic [2:0]   ch_rd_idx;
   logic [31:0]  ch_rdata;
   logic         res_done;
   logic [2:0]   res_code;
   logic [4:0]   rd_count;
   logic [127:0] rd_data;

   // responder configuration, driven by tasks
   logic         cfg_done = 1'b1;
   logic         cfg_to = 1'b0;
   logic         cfg_rx = 1'b0;
   logic [4:0]   cfg_size = 5'd1;
   logic [1:0]   cfg_code = 2'd0;
   int           cfg_defers = 0;
   logic         tb_clr = 1'b0;
   logic [7:0]   rb [20];

   // responder state
   logic         r_busy;
   int           r_cnt;
   logic [1:0]   cur_code;
   int           nsend, nclear, nwr, ndone;
   logic [31:0]  cap [8];
   logic [31:0]  last_send, last_clear;

   int checks = 0;
   int fails  = 0;

   aux_native_framer u_dut (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_is_read(req_is_read),
      .req_addr(req_addr), .req_len(req_len), .req_payload(req_payload),
      .ch_data_wr(ch_data_wr), .ch_data_idx(ch_data_idx), .ch_data_wdata(ch_data_wdata),
      .ch_ctl_wr(ch_ctl_wr), .ch_ctl_wdata(ch_ctl_wdata), .ch_status(ch_status),
      .ch_rd_idx(ch_rd_idx), .ch_rdata(ch_rdata), .res_done(res_done),
      .res_code(res_code), .rd_count(rd_count), .rd_data(rd_data)
   );

   always #10 clk = ~clk;

   always_ff @(posedge clk) begin
      if (tb_clr) begin
         nsend <= 0; nclear <= 0; nwr <= 0; ndone <= 0; r_busy <= 1'b0; r_cnt <= 0;
         for (int i = 0; i < 8; i++) cap[i] <= '0;
      end else begin
         if (res_done) ndone <= ndone + 1;
         if (ch_data_wr) begin
            cap[ch_data_idx] <= ch_data_wdata;
            nwr <= nwr + 1;
         end
         if (ch_ctl_wr && ch_ctl_wdata[31]) begin
            r_busy    <= 1'b1;
            r_cnt     <= 3;
            nsend     <= nsend + 1;
            last_send <= ch_ctl_wdata;
            cur_code  <= (nsend < cfg_defers) ? 2'd2 : cfg_code;
         end else if (ch_ctl_wr) begin
            nclear     <= nclear + 1;
            last_clear <= ch_ctl_wdata;
         end
         if (r_busy) begin
            if (r_cnt <= 1) r_busy <= 1'b0;
            r_cnt <= r_cnt - 1;
         end
      end
   end

   assign ch_status = {r_busy, cfg_done, cfg_to, cfg_rx, 2'b11, 1'b0, cfg_size, 20'h0};

   always_comb begin
      int b;
      b = 4 * int'(ch_rd_idx);
      ch_rdata = '0;
      if (b < 20) begin
         ch_rdata = {rb[b], rb[b+1], rb[b+2], rb[b+3]};
         if (ch_rd_idx == 3'd0) ch_rdata[31:24] = {2'b00, cur_code, 4'h0};
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ctl_exp(input bit clear, input int size);
      logic [31:0] w;
      w = 32'h3000_0000 | (32'd3 << 26) | (32'(size) << 20) | (32'd5 << 16) | 32'd133;
      w |= clear ? 32'h4000_0000 : 32'h8000_0000;
      return w;
   endfunction

   task automatic set_resp(input bit d, input bit t, input bit r, input int size,
                           input logic [1:0] code, input int defers);
      cfg_done = d; cfg_to = t; cfg_rx = r; cfg_size = 5'(size);
      cfg_code = code; cfg_defers = defers;
      for (int i = 0; i < 20; i++) rb[i] = 8'(8'hA0 + i);
   endtask

   task automatic run(input bit rd, input logic [15:0] a, input int len, input logic [127:0] pay);
      @(negedge clk); tb_clr = 1'b1;
      @(negedge clk); tb_clr = 1'b0;
      req_is_read = rd; req_addr = a; req_len = 5'(len); req_payload = pay; req_start = 1'b1;
      @(negedge clk); req_start = 1'b0;
      for (int i = 0; i < 400; i++) begin
         if (res_done) break;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      chk(res_done == 0 && res_code == 0 && rd_count == 0, "R11 reset outputs", res_code, 0);
      chk(!ch_data_wr && !ch_ctl_wr, "R2 reset strobes", {ch_data_wr, ch_ctl_wr}, 0);
   endtask

   task automatic t_write_short();
      set_resp(1, 0, 0, 1, 2'd0, 0);
      run(0, 16'h1234, 3, 128'h00CC_BBAA);
      chk(cap[0] == 32'h8012_3402, "R1 write header word", cap[0], 32'h8012_3402);
      chk(cap[1] == 32'hAABB_CC00, "R2 payload word zero fill", cap[1], 32'hAABB_CC00);
      chk(nwr == 2, "R2 word count", nwr, 2);
      chk(last_send == ctl_exp(0, 7), "R3 start control word", last_send, ctl_exp(0, 7));
      chk(nclear == 1 && last_clear == ctl_exp(1, 7), "R4 clearing word", last_clear, ctl_exp(1, 7));
      chk(res_code == 0 && rd_count == 0, "R7 write ack", res_code, 0);
   endtask

   task automatic t_read();
      set_resp(1, 0, 0, 6, 2'd0, 0);
      rb[1] = 8'h11; rb[2] = 8'h22; rb[3] = 8'h33; rb[4] = 8'h44; rb[5] = 8'h55; rb[6] = 8'h66;
      run(1, 16'h0202, 5, '1);
      chk(cap[0] == 32'h9002_0204 && nwr == 1, "R1 read header", cap[0], 32'h9002_0204);
      chk(last_send == ctl_exp(0, 4), "R3 read size", last_send, ctl_exp(0, 4));
      chk(res_code == 0 && rd_count == 5, "R7 read count", rd_count, 5);
      chk(rd_data[39:0] == 40'h55_4433_2211, "R7 read bytes", rd_data[39:0], 40'h55_4433_2211);
      chk(rd_data[127:40] == '0, "R7 bytes past count zero", rd_data[127:40], 0);
   endtask

   task automatic t_clip();
      set_resp(1, 0, 0, 12, 2'd0, 0);
      run(1, 16'h0010, 2, '0);
      chk(rd_count == 2, "R6 clipped count", rd_count, 2);
      chk(rd_data[15:0] == 16'hA2A1 && rd_data[127:16] == '0, "R6 clipped bytes", rd_data[23:0], 24'h00A2A1);
   endtask

   task automatic t_write_full();
      logic [127:0] p;
      for (int i = 0; i < 16; i++) p[8*i +: 8] = 8'(i + 1);
      set_resp(1, 0, 0, 1, 2'd0, 0);
      run(0, 16'hABCD, 16, p);
      chk(nwr == 5 && cap[0] == 32'h80AB_CD0F, "R1 full header", cap[0], 32'h80AB_CD0F);
      chk(cap[1] == 32'h0102_0304 && cap[4] == 32'h0D0E_0F10, "R2 full words", cap[4], 32'h0D0E_0F10);
      chk(last_send == ctl_exp(0, 20), "R3 full size", last_send, ctl_exp(0, 20));
   endtask

   task automatic t_defer();
      set_resp(1, 0, 0, 1, 2'd0, 2);
      run(0, 16'h0100, 1, 128'h5A);
      chk(nsend == 3 && res_code == 0, "R8 defer then ack", nsend, 3);
      set_resp(1, 0, 0, 1, 2'd0, 100);
      run(0, 16'h0100, 1, 128'h5A);
      chk(nsend == 7, "R8 try limit", nsend, 7);
      chk(res_code == 2 && rd_count == 0, "R8 defer limit result", res_code, 2);
   endtask

   task automatic t_nack();
      set_resp(1, 0, 0, 4, 2'd1, 0);
      run(1, 16'h0000, 3, '0);
      chk(res_code == 1 && rd_count == 0 && rd_data == '0, "R9 nack", res_code, 1);
      set_resp(1, 0, 0, 4, 2'd3, 0);
      run(1, 16'h0000, 3, '0);
      chk(res_code == 1, "R9 reserved code", res_code, 1);
   endtask

   task automatic t_errors();
      set_resp(1, 1, 0, 2, 2'd0, 0);
      run(1, 16'h0300, 1, '0);
      chk(res_code == 3 && nclear == 1, "R5 timeout", res_code, 3);
      set_resp(1, 1, 1, 2, 2'd0, 0);
      run(1, 16'h0300, 1, '0);
      chk(res_code == 4, "R5 rx error before timeout", res_code, 4);
      set_resp(0, 0, 1, 2, 2'd0, 0);
      run(1, 16'h0300, 1, '0);
      chk(res_code == 5 && rd_count == 0, "R5 not done first", res_code, 5);
      set_resp(1, 0, 0, 0, 2'd0, 0);
      run(1, 16'h0300, 1, '0);
      chk(res_code == 4, "R6 empty reply", res_code, 4);
   endtask

   task automatic t_badlen();
      set_resp(1, 0, 0, 1, 2'd0, 0);
      run(0, 16'h0001, 0, '0);
      chk(res_code == 6 && nwr == 0 && nsend == 0, "R10 zero length", res_code, 6);
      run(0, 16'h0001, 17, '0);
      chk(res_code == 6 && nwr == 0 && nsend == 0, "R10 over length", res_code, 6);
   endtask

   task automatic t_ignore_start();
      set_resp(1, 0, 0, 1, 2'd0, 0);
      @(negedge clk); tb_clr = 1'b1;
      @(negedge clk); tb_clr = 1'b0;
      req_is_read = 0; req_addr = 16'h0042; req_len = 5'd2; req_payload = 128'h0201; req_start = 1'b1;
      @(negedge clk); req_start = 1'b0;
      @(negedge clk); @(negedge clk);
      req_len = 5'd0; req_start = 1'b1;
      @(negedge clk); req_start = 1'b0;
      for (int i = 0; i < 400; i++) begin
         if (res_done) break;
         @(negedge clk);
      end
      chk(res_code == 0, "R11 start ignored while busy", res_code, 0);
      repeat (20) @(negedge clk);
      chk(ndone == 1 && nsend == 1, "R11 single done pulse", ndone, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_short();
      t_read();
      t_clip();
      t_write_full();
      t_defer();
      t_nack();
      t_errors();
      t_badlen();
      t_ignore_start();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule